// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter Chain

This block is a synchronous binary up-counter built from 4-bit stages that are chained into one wider counter. Every stage register updates together on the rising clock edge. The counter can be preset from a parallel data word. It can be cleared either at once or at the next clock edge, and a build-time parameter picks which. Counting is gated by two enables.

Enable P goes to every stage. Enable T goes only to the lowest stage. Each stage raises its carry-out when it holds all ones and its own T input is high. That carry drives the T input of the stage above it, so the chain counts as one wide counter with no extra gating. The top-level carry output lets several chains be linked in the same way, or lets outside logic decode the terminal count. For example, feeding a decoded count back into the clear input in synchronous-clear mode gives a modulo-N counter.

Top module: `bcnt_chain`

## Requirements
- R1: The count output changes only on a rising clock edge, and all of its bits take their new value at that same edge.
- R2: With ASYNC_CLR=1, a low `clr_n` forces the count output to zero without waiting for a clock edge, whatever `load_n`, `en_p` and `en_t` are.
- R3: With ASYNC_CLR=0, a low `clr_n` leaves the count unchanged until the next rising edge, and the count is zero after that edge whatever the enables are.
- R4: When `clr_n` is high and `load_n` is low, the count equals `din` after the next rising edge, whatever the enables are.
- R5: When `clr_n` and `load_n` are high and both `en_p` and `en_t` are high, each rising edge adds one to the count. All ones is followed by zero.
- R6: When `clr_n` and `load_n` are high and either enable is low, the count holds its value.
- R7: Clear takes priority over load: if both are low at an edge, the count becomes zero.
- R8: `rco` is high exactly when every count bit is 1 and `en_t` is high. `en_p` does not affect it, and it follows `en_t` within the same cycle.
- R9: Each stage above the lowest advances only when every stage below it holds all ones, so the chain of STAGES stages behaves as one STAGES*SW-bit binary counter.
- R10: A change of `load_n`, `en_p` or `en_t` between edges leaves the count unchanged until the next rising edge.
- R11: In synchronous-clear mode, driving `clr_n` low when the count equals N-1 makes the counter cycle through 0 to N-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the count updates on the rising edge |
| clr_n | input | 1 | Active-low clear; immediate or edge-timed, depending on ASYNC_CLR |
| load_n | input | 1 | Active-low parallel preset |
| en_p | input | 1 | Count enable routed to every stage |
| en_t | input | 1 | Count enable for the lowest stage; also gates the carry output |
| din | input | STAGES*SW | Parallel preset value |
| q | output | STAGES*SW | Registered count |
| rco | output | 1 | Carry out: count is all ones and en_t is high |

## Verification
The hardest situation to reach from the ports is the carry rippling through every stage at once: the top stage only moves when all lower stages hold all ones. The bench reaches this by counting the whole 12-bit range from zero, and then by preloading values just below the stage boundaries and stepping across them. It steps with enable patterns taken from a bench-side shift register, so that holds land on those boundaries. A second instance built with the other clear mode receives a clear in the middle of a cycle, so that the immediate zero can be observed before the edge. The edge-timed instance is then wired as a modulo-ten counter through its clear input.

// File: rtl/bcnt_pkg.sv
package bcnt_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } bcnt_mode_e;
endpackage

// File: rtl/bcnt_ctrl.sv
module bcnt_ctrl
  import bcnt_pkg::*;
(
  input  logic       clr_n,
  input  logic       load_n,
  input  logic       en_p,
  input  logic       en_t,
  output bcnt_mode_e mode
);
  // clear beats load, load beats count, count beats hold
  always_comb begin
    if (!clr_n)             mode = MODE_CLEAR;
    else if (!load_n)       mode = MODE_LOAD;
    else if (en_p && en_t)  mode = MODE_COUNT;
    else                    mode = MODE_HOLD;
  end
endmodule

// File: rtl/bcnt_stage.sv
module bcnt_stage
  import bcnt_pkg::*;
#(
  parameter int SW        = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          load_n,
  input  logic          en_p,
  input  logic          en_t,
  input  logic [SW-1:0] din,
  output logic [SW-1:0] q,
  output logic          rco
);
  bcnt_mode_e    mode;
  logic [SW-1:0] cnt_r;
  logic [SW-1:0] cnt_nxt;

  bcnt_ctrl u_ctrl (
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .mode   (mode)
  );

  always_comb begin
    unique case (mode)
      MODE_CLEAR: cnt_nxt = '0;
      MODE_LOAD:  cnt_nxt = din;
      MODE_COUNT: cnt_nxt = cnt_r + SW'(1);
      default:    cnt_nxt = cnt_r;
    endcase
  end

  generate
    if (ASYNC_CLR) begin : g_async_clr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) cnt_r <= '0;
        else        cnt_r <= cnt_nxt;
      end
    end else begin : g_sync_clr
      always_ff @(posedge clk) begin
        cnt_r <= cnt_nxt;
      end
    end
  endgenerate

  assign q   = cnt_r;
  assign rco = (&cnt_r) & en_t;
endmodule

// File: rtl/bcnt_chain.sv
module bcnt_chain #(
  parameter int SW        = 4,
  parameter int STAGES    = 3,
  parameter bit ASYNC_CLR = 1'b0,
  localparam int TOTAL    = SW * STAGES
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [TOTAL-1:0] din,
  output logic [TOTAL-1:0] q,
  output logic             rco
);
  logic [STAGES:0] carry;

  assign carry[0] = en_t;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      bcnt_stage #(
        .SW        (SW),
        .ASYNC_CLR (ASYNC_CLR)
      ) u_stage (
        .clk    (clk),
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_p   (en_p),
        .en_t   (carry[s]),
        .din    (din[s*SW +: SW]),
        .q      (q[s*SW +: SW]),
        .rco    (carry[s+1])
      );
    end
  endgenerate

  assign rco = carry[STAGES];
endmodule

// File: rtl/bcnt_chain_chk.sv
module bcnt_chain_chk #(
  parameter int TOTAL     = 12,
  parameter bit ASYNC_CLR = 1'b0
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic             en_p,
  input logic             en_t,
  input logic [TOTAL-1:0] din,
  input logic [TOTAL-1:0] q,
  input logic             rco
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R3 R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> (q == '0));

  // R4
  load_value_chk: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !load_n) |=> (!clr_n || q == $past(din)));

  // R5 R9
  count_step_chk: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && en_p && en_t) |=> (!clr_n || q == $past(q) + TOTAL'(1)));

  // R6
  hold_value_chk: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && !(en_p && en_t)) |=> (!clr_n || $stable(q)));

  // R8
  carry_high_chk: assert property (@(posedge clk) disable iff (!armed)
    rco |-> ((&q) && en_t));

  // R8
  carry_term_chk: assert property (@(posedge clk) disable iff (!armed)
    ((&q) && en_t) |-> rco);

  generate
    if (ASYNC_CLR) begin : g_async
      // R2
      async_zero_chk: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |-> (q == '0));
    end
  endgenerate
endmodule

bind bcnt_chain bcnt_chain_chk #(
  .TOTAL     (TOTAL),
  .ASYNC_CLR (ASYNC_CLR)
) u_chk (
  .clk    (clk),
  .clr_n  (clr_n),
  .load_n (load_n),
  .en_p   (en_p),
  .en_t   (en_t),
  .din    (din),
  .q      (q),
  .rco    (rco)
);

// File: tb/bcnt_chain_tb.sv
module bcnt_chain_tb;
  localparam int SW    = 4;
  localparam int ST    = 3;
  localparam int W     = SW * ST;
  localparam int MODN  = 10;

  logic         clk = 1'b0;
  logic         clr_drv = 1'b0;
  logic         clr_a = 1'b0;
  logic         mod_on = 1'b0;
  logic         load_n = 1'b1;
  logic         en_p = 1'b0;
  logic         en_t = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q, q_a;
  logic         rco, rco_a;
  logic         clr_s;

  int total = 0;
  int fails = 0;
  logic [W-1:0] model = '0;
  logic [15:0]  lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  // R11: terminal-count decode drives the edge-timed clear
  assign clr_s = mod_on ? (q != W'(MODN-1)) : clr_drv;

  bcnt_chain #(.SW(SW), .STAGES(ST), .ASYNC_CLR(1'b0)) u_dut (
    .clk(clk), .clr_n(clr_s), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(q), .rco(rco));

  bcnt_chain #(.SW(SW), .STAGES(ST), .ASYNC_CLR(1'b1)) u_async (
    .clk(clk), .clr_n(clr_a), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(q_a), .rco(rco_a));

  task automatic chk(input logic ok, input string rq, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // inputs set just after a falling edge; results read after the next rising edge
  task automatic tick(input logic c, input logic l, input logic p, input logic t,
                      input logic [W-1:0] d, input string rq);
    clr_drv = c; clr_a = c; load_n = l; en_p = p; en_t = t; din = d;
    #1;
    chk(rco == ((&model) && t), "R8", W'(rco), W'((&model) && t));
    chk(q == model, "R10", q, model);
    if (!c)           model = '0;
    else if (!l)      model = d;
    else if (p && t)  model = model + W'(1);
    @(posedge clk); #1;
    chk(q == model, rq, q, model);
    chk(q_a == model, rq, q_a, model);
    @(negedge clk);
  endtask

  initial begin
    #500000;
    fails++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(1'b0, 1'b1, 1'b1, 1'b1, '0, "R3");
    chk(q == '0 && rco == 1'b0, "R3", q, '0);
    // full sweep of the chain, wrap included
    for (int i = 0; i < (1 << W); i++) tick(1'b1, 1'b1, 1'b1, 1'b1, '0, "R9");
    chk(q == '0, "R5", q, '0);
    // load regardless of enables
    tick(1'b1, 1'b0, 1'b0, 1'b0, 12'h5A3, "R4");
    tick(1'b1, 1'b0, 1'b1, 1'b1, 12'h0FE, "R4");
    // hold when either enable low
    tick(1'b1, 1'b1, 1'b0, 1'b1, '0, "R6");
    tick(1'b1, 1'b1, 1'b1, 1'b0, '0, "R6");
    tick(1'b1, 1'b1, 1'b0, 1'b0, '0, "R6");
    // step across stage boundaries under pseudo-random enables
    for (int b = 0; b < 6; b++) begin
      logic [W-1:0] base;
      base = (b < 3) ? W'((1 << (SW*(b+1))) - 3) : W'(12'hFFD);
      tick(1'b1, 1'b0, 1'b0, 1'b0, base, "R4");
      for (int k = 0; k < 12; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tick(1'b1, 1'b1, lfsr[0] | lfsr[3], lfsr[1] | lfsr[5], '0, "R9");
      end
    end
    // carry: en_p has no effect, follows en_t
    tick(1'b1, 1'b0, 1'b0, 1'b0, 12'hFFF, "R4");
    en_p = 1'b0; en_t = 1'b1; #1;
    chk(rco == 1'b1, "R8", W'(rco), W'(1));
    en_t = 1'b0; #1;
    chk(rco == 1'b0, "R8", W'(rco), W'(0));
    tick(1'b1, 1'b1, 1'b0, 1'b1, '0, "R6");
    // mid-cycle control glitch: load low then released before the edge
    tick(1'b1, 1'b0, 1'b0, 1'b0, 12'h123, "R4");
    load_n = 1'b0; din = 12'h777; en_p = 1'b1; en_t = 1'b1; #1;
    chk(q == 12'h123, "R10", q, 12'h123);
    load_n = 1'b1; #1;
    chk(q == 12'h123, "R10", q, 12'h123);
    model = 12'h124;
    @(posedge clk); #1;
    chk(q == 12'h124, "R10", q, 12'h124);
    chk(q_a == 12'h124, "R1", q_a, 12'h124);
    @(negedge clk);
    // clear beats load
    tick(1'b0, 1'b0, 1'b1, 1'b1, 12'hABC, "R7");
    // mid-cycle clear: immediate on async instance, deferred on sync one
    tick(1'b1, 1'b0, 1'b0, 1'b0, 12'h9D4, "R4");
    clr_drv = 1'b0; clr_a = 1'b0; load_n = 1'b0; en_p = 1'b1; en_t = 1'b1; #1;
    chk(q_a == '0, "R2", q_a, '0);
    chk(q == 12'h9D4, "R3", q, 12'h9D4);
    model = '0;
    @(posedge clk); #1;
    chk(q == '0, "R3", q, '0);
    chk(q_a == '0, "R2", q_a, '0);
    @(negedge clk);
    // modulo-N through edge-timed clear
    clr_drv = 1'b1; load_n = 1'b1; en_p = 1'b1; en_t = 1'b1; mod_on = 1'b1;
    for (int i = 1; i <= 3*MODN; i++) begin
      @(posedge clk); #1;
      chk(q == W'(i % MODN), "R11", q, W'(i % MODN));
    end
    mod_on = 1'b0;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule